// File: doc/BRIEF.md
# Memory-Access Legality Checker

This block watches a stream of memory access requests and reports any request whose outcome would be architecturally undefined for the memory type it targets. Each request carries these fields: a start address, a byte count, a memory type, qualifiers for multi-access, instruction fetch and program-counter transfer, the current MMU-enable state, and, for vector element loads, the first and last byte addresses that the instruction explicitly names. The block does not stall, alter or drop the access. It only observes.

Each sampled request produces a registered result one cycle later. `viol_o` pulses for one cycle when a rule is broken, and `reason_o` gives the rule that was broken. Four rules are checked. A multi-access request must not cross a 4 KB page. An instruction fetch must not target non-Normal memory. A multi-access transfer of the program counter must not target non-Normal memory while translation is on. A vector load must not over-read outside a single 16-byte-aligned window that also holds explicit bytes. When several rules are broken at once, a fixed priority selects one code.

Top module: `acc_legal_chk`

## Requirements
- R1: `viol_o` and `reason_o` are 0 in reset. They are also 0 in the cycle after a clock edge at which `req_valid_i` is low. Otherwise they reflect the request sampled at the previous rising edge. `viol_o` is high exactly when `reason_o` is nonzero.
- R2: A request with `multi_i` high to non-Normal memory and a nonzero byte count reports code 1 when bits [31:12] of `addr_i` differ from bits [31:12] of `addr_i + nbytes_i - 1`.
- R3: A request with `fetch_i` high to non-Normal memory reports a violation with code 2, unless a lower code applies.
- R4: A request with `multi_i`, `pc_xfer_i` and `mmu_en_i` all high to non-Normal memory reports code 3, unless a lower code applies.
- R5: While `mmu_en_i` is low, the program-counter rule never fires. The other rules are unaffected.
- R6: A request with `vec_ld_i` high to non-Normal memory may touch bytes outside the explicit span [`span_lo_i`, `span_hi_i`] only if every touched byte lies in one 16-byte-aligned window that overlaps the span. If it breaks this rule, it reports code 4.
- R7: Memory type encoding is 0 = Normal, 1 = Device, 2 = strongly ordered, and 3 = reserved, which is treated as non-Normal. Requests with type 0 never raise a violation.
- R8: When several rules are broken by one request, the smallest nonzero code is reported.
- R9: A byte count of zero touches no bytes. It never causes a page-crossing or over-read violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| addr_i | input | 32 | Address of first touched byte |
| nbytes_i | input | 8 | Number of bytes touched |
| mem_type_i | input | 2 | Memory type (see R7) |
| multi_i | input | 1 | Request is part of a multi-access instruction |
| fetch_i | input | 1 | Request is an instruction fetch |
| pc_xfer_i | input | 1 | Request loads or stores the program counter |
| mmu_en_i | input | 1 | Address translation enabled |
| vec_ld_i | input | 1 | Request is a vector element or structure load |
| span_lo_i | input | 32 | First explicitly accessed byte of a vector load |
| span_hi_i | input | 32 | Last explicitly accessed byte of a vector load |
| viol_o | output | 1 | One-cycle violation pulse |
| reason_o | output | 3 | Violation code, 0 when none |

## Verification
The assertions assume some things about the inputs. The touched range `addr_i` to `addr_i + nbytes_i - 1` does not wrap past the top of the address space. `span_lo_i` is not above `span_hi_i`. All request fields are stable over the cycle in which `req_valid_i` is sampled. The stimulus uses start addresses well below the top of memory and chosen near page and window edges. It builds every span from the start address with non-negative offsets, and it drives every field at the falling edge. The sweep also covers every memory type and every combination of the five qualifier bits, so the priority and suppression paths are reached with all other rules both active and inactive.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [1:0] {
    MT_NORMAL = 2'd0,
    MT_DEVICE = 2'd1,
    MT_STRONG = 2'd2,
    MT_RSVD   = 2'd3
  } mem_type_e;

  // rule order is also the priority order (bit 0 wins)
  typedef enum int unsigned {
    RULE_PAGE  = 0,
    RULE_FETCH = 1,
    RULE_PC    = 2,
    RULE_VEC   = 3
  } rule_e;

  localparam int unsigned NUM_RULES = 4;
  localparam int unsigned CODE_W    = $clog2(NUM_RULES + 1);

  typedef logic [NUM_RULES-1:0] rule_vec_t;

endpackage

// File: rtl/alc_extent.sv
module alc_extent #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned WIN_BITS  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  output logic [ADDR_W-1:0] last_o,
  output logic              has_bytes_o,
  output logic              page_cross_o,
  output logic              same_win_o,
  output logic [ADDR_W-1:0] win_base_o,
  output logic [ADDR_W-1:0] win_top_o
);

  localparam int unsigned PAGE_TAG_W = ADDR_W - PAGE_BITS;
  localparam int unsigned WIN_TAG_W  = ADDR_W - WIN_BITS;

  logic [ADDR_W-1:0] span_len;

  assign has_bytes_o = |nbytes_i;

  generate
    if (ADDR_W > CNT_W) begin : g_zext
      assign span_len = {{(ADDR_W-CNT_W){1'b0}}, nbytes_i};
    end else begin : g_trunc
      assign span_len = nbytes_i[ADDR_W-1:0];
    end
  endgenerate

  // a zero count collapses onto the first byte
  assign last_o = has_bytes_o ? (addr_i + span_len - ADDR_W'(1)) : addr_i;

  assign page_cross_o = addr_i[ADDR_W-1 -: PAGE_TAG_W] != last_o[ADDR_W-1 -: PAGE_TAG_W];
  assign same_win_o   = addr_i[ADDR_W-1 -: WIN_TAG_W]  == last_o[ADDR_W-1 -: WIN_TAG_W];

  assign win_base_o = {addr_i[ADDR_W-1 -: WIN_TAG_W], {WIN_BITS{1'b0}}};
  assign win_top_o  = {addr_i[ADDR_W-1 -: WIN_TAG_W], {WIN_BITS{1'b1}}};

endmodule

// File: rtl/alc_vec_window.sv
module alc_vec_window #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              has_bytes_i,
  input  logic              same_win_i,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic [ADDR_W-1:0] win_top_i,
  input  logic [ADDR_W-1:0] span_lo_i,
  input  logic [ADDR_W-1:0] span_hi_i,
  output logic              bad_o
);

  logic outside_lo, outside_hi, over_read, win_hits_span, window_ok;

  assign outside_lo    = first_i < span_lo_i;
  assign outside_hi    = last_i  > span_hi_i;
  assign over_read     = has_bytes_i && (outside_lo || outside_hi);
  assign win_hits_span = (span_lo_i <= win_top_i) && (span_hi_i >= win_base_i);
  assign window_ok     = same_win_i && win_hits_span;
  assign bad_o         = over_read && !window_ok;

endmodule

// File: rtl/alc_prio.sv
module alc_prio #(
  parameter int unsigned N      = 4,
  parameter int unsigned CODE_W = $clog2(N + 1)
) (
  input  logic [N-1:0]      hits_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);

  assign any_o = |hits_i;

  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) code_o = CODE_W'(i + 1);
    end
  end

endmodule

// File: rtl/acc_legal_chk.sv
module acc_legal_chk
  import alc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned WIN_BITS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [1:0]        mem_type_i,
  input  logic              multi_i,
  input  logic              fetch_i,
  input  logic              pc_xfer_i,
  input  logic              mmu_en_i,
  input  logic              vec_ld_i,
  input  logic [ADDR_W-1:0] span_lo_i,
  input  logic [ADDR_W-1:0] span_hi_i,
  output logic              viol_o,
  output logic [CODE_W-1:0] reason_o
);

  logic [ADDR_W-1:0] last_addr, win_base, win_top;
  logic              has_bytes, page_cross, same_win, vec_bad;
  logic              non_normal, any_hit;
  rule_vec_t         hits;
  logic [CODE_W-1:0] code_d;
  logic              viol_q;
  logic [CODE_W-1:0] reason_q;

  assign non_normal = mem_type_e'(mem_type_i) != MT_NORMAL;

  alc_extent #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .PAGE_BITS(PAGE_BITS),
    .WIN_BITS (WIN_BITS)
  ) i_extent (
    .addr_i      (addr_i),
    .nbytes_i    (nbytes_i),
    .last_o      (last_addr),
    .has_bytes_o (has_bytes),
    .page_cross_o(page_cross),
    .same_win_o  (same_win),
    .win_base_o  (win_base),
    .win_top_o   (win_top)
  );

  alc_vec_window #(
    .ADDR_W(ADDR_W)
  ) i_vec_window (
    .first_i    (addr_i),
    .last_i     (last_addr),
    .has_bytes_i(has_bytes),
    .same_win_i (same_win),
    .win_base_i (win_base),
    .win_top_i  (win_top),
    .span_lo_i  (span_lo_i),
    .span_hi_i  (span_hi_i),
    .bad_o      (vec_bad)
  );

  always_comb begin
    hits             = '0;
    hits[RULE_PAGE]  = multi_i && has_bytes && page_cross;
    hits[RULE_FETCH] = fetch_i;
    hits[RULE_PC]    = multi_i && pc_xfer_i && mmu_en_i;
    hits[RULE_VEC]   = vec_ld_i && vec_bad;
    if (!non_normal) hits = '0;
  end

  alc_prio #(
    .N     (NUM_RULES),
    .CODE_W(CODE_W)
  ) i_prio (
    .hits_i(hits),
    .any_o (any_hit),
    .code_o(code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q   <= 1'b0;
      reason_q <= '0;
    end else begin
      viol_q   <= req_valid_i && any_hit;
      reason_q <= req_valid_i ? code_d : '0;
    end
  end

  assign viol_o   = viol_q;
  assign reason_o = reason_q;

endmodule

// File: rtl/alc_checker.sv
module alc_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [CNT_W-1:0] nbytes_i,
  input logic [1:0]       mem_type_i,
  input logic             multi_i,
  input logic             fetch_i,
  input logic             pc_xfer_i,
  input logic             mmu_en_i,
  input logic             vec_ld_i,
  input logic             viol_o,
  input logic [2:0]       reason_o
);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !viol_o);

  a_r1_pulse_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (reason_o != 3'd0));

  a_r1_code_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_o |-> (reason_o == 3'd0));

  a_r7_normal_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mem_type_i == 2'd0) |=> !viol_o);

  a_r3_fetch_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fetch_i && mem_type_i != 2'd0) |=> (viol_o && reason_o <= 3'd2));

  a_r2_page_needs_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reason_o == 3'd1) |-> $past(multi_i));

  a_r5_pc_needs_mmu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reason_o == 3'd3) |-> $past(multi_i && pc_xfer_i && mmu_en_i));

  a_r6_vec_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reason_o == 3'd4) |-> $past(vec_ld_i));

  a_r9_empty_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && nbytes_i == '0 && !fetch_i && !(multi_i && pc_xfer_i && mmu_en_i))
      |=> !viol_o);

endmodule

bind acc_legal_chk alc_checker #(.CNT_W(CNT_W)) i_alc_checker (.*);

// File: tb/test_acc_legal_chk.sv
`timescale 1ns/1ps
module test_acc_legal_chk;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [7:0]  nbytes_i = '0;
  logic [1:0]  mem_type_i = '0;
  logic        multi_i = 1'b0, fetch_i = 1'b0, pc_xfer_i = 1'b0;
  logic        mmu_en_i = 1'b0, vec_ld_i = 1'b0;
  logic [31:0] span_lo_i = '0, span_hi_i = '0;
  logic        viol_o;
  logic [2:0]  reason_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  acc_legal_chk i_acc_legal_chk (
    .clk_i, .rst_ni, .req_valid_i, .addr_i, .nbytes_i, .mem_type_i,
    .multi_i, .fetch_i, .pc_xfer_i, .mmu_en_i, .vec_ld_i,
    .span_lo_i, .span_hi_i, .viol_o, .reason_o
  );

  task automatic check(input string tag, input logic v, input logic [2:0] r,
                       input logic ev, input logic [2:0] er);
    n_cmp++;
    if (v !== ev || r !== er) begin
      n_bad++;
      $display("FAIL %s: viol=%0b reason=%0d expected viol=%0b reason=%0d (addr=%h n=%0d type=%0d)",
               tag, v, r, ev, er, addr_i, nbytes_i, mem_type_i);
    end
  endtask

  function automatic logic [2:0] model(input logic [31:0] a, input int n, input logic [1:0] t,
                                       input logic mu, input logic fe, input logic pc,
                                       input logic mm, input logic ve,
                                       input logic [31:0] lo, input logic [31:0] hi,
                                       output int nrules);
    logic        nn, e1, e2, e3, e4, over, same, inter;
    logic [31:0] last, base;
    nn    = (t != 2'd0);
    last  = (n == 0) ? a : a + 32'(n) - 32'd1;
    base  = a & 32'hFFFF_FFF0;
    e1    = nn && mu && (n != 0) && ((a / 4096) != (last / 4096));
    e2    = nn && fe;
    e3    = nn && mu && pc && mm;
    over  = (n != 0) && (a < lo || last > hi);
    same  = (a / 16) == (last / 16);
    inter = (lo <= base + 32'd15) && (hi >= base);
    e4    = nn && ve && over && !(same && inter);
    nrules = int'(e1) + int'(e2) + int'(e3) + int'(e4);
    if (e1) return 3'd1;
    if (e2) return 3'd2;
    if (e3) return 3'd3;
    if (e4) return 3'd4;
    return 3'd0;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] addrs [6];
    int          cnts [6];
    addrs = '{32'h0000_1000, 32'h0000_1FF8, 32'h0000_1FFC,
              32'h0000_2003, 32'h0000_2FFF, 32'h0000_3004};
    cnts  = '{0, 1, 4, 8, 16, 20};

    repeat (3) @(negedge clk_i);
    check("R1 reset", viol_o, reason_o, 1'b0, 3'd0);
    rst_ni = 1'b1;

    // idle cycle with every rule armed: no report (R1)
    addr_i = 32'h0000_1FFC; nbytes_i = 8'd8; mem_type_i = 2'd1;
    multi_i = 1; fetch_i = 1; pc_xfer_i = 1; mmu_en_i = 1; vec_ld_i = 1;
    span_lo_i = 32'h100; span_hi_i = 32'h100;
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1 idle", viol_o, reason_o, 1'b0, 3'd0);

    req_valid_i = 1'b1;
    for (int t = 0; t < 4; t++) begin
      for (int f = 0; f < 32; f++) begin
        for (int ai = 0; ai < 6; ai++) begin
          for (int ci = 0; ci < 6; ci++) begin
            for (int sv = 0; sv < 3; sv++) begin
              logic [31:0] a, last, lo, hi;
              logic [2:0]  er;
              int          nr;
              string       tag;
              a    = addrs[ai];
              last = (cnts[ci] == 0) ? a : a + 32'(cnts[ci]) - 32'd1;
              case (sv)
                0: begin lo = a;         hi = last;        end
                1: begin lo = a + 32'd1; hi = a + 32'd1;   end
                default: begin lo = a + 32'h40; hi = a + 32'h40; end
              endcase
              addr_i = a; nbytes_i = 8'(cnts[ci]); mem_type_i = 2'(t);
              multi_i = f[0]; fetch_i = f[1]; pc_xfer_i = f[2];
              mmu_en_i = f[3]; vec_ld_i = f[4];
              span_lo_i = lo; span_hi_i = hi;
              er = model(a, cnts[ci], 2'(t), f[0], f[1], f[2], f[3], f[4], lo, hi, nr);
              if (nr > 1)                                tag = "R8 priority";
              else if (t == 0)                           tag = "R7 normal";
              else if (cnts[ci] == 0)                    tag = "R9 empty";
              else if (er == 3'd1)                       tag = "R2 page";
              else if (er == 3'd2)                       tag = "R3 fetch";
              else if (er == 3'd3)                       tag = "R4 pc";
              else if (f[0] && f[2] && !f[3])            tag = "R5 mmu off";
              else if (er == 3'd4 || f[4])               tag = "R6 vector";
              else                                       tag = "R1 clean";
              @(negedge clk_i);
              check(tag, viol_o, reason_o, er != 3'd0, er);
            end
          end
        end
      end
    end

    // back-to-back then idle: pulse lasts one cycle (R1)
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1 pulse end", viol_o, reason_o, 1'b0, 3'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule